// File: doc/BRIEF.md
# Indexed Byte-Store Access Port

This block places a byte-wide memory of up to 8 KiB behind a small four-offset I/O window. A host first loads a 16-bit pointer, one byte at a time, through two of the offsets. It then reads or writes the byte at that pointer through a third offset, the data offset. A data write stores the byte and then returns the pointer to zero, so every store must be preceded by a fresh pointer load. A data read leaves the pointer where it is, so the same location can be read again at once.

Two 16-byte protection windows sit low in the memory. Each window has a lock bit, and a host-side request flips that bit. While a window is locked, stores into it are discarded and loads from it return all ones. Pointers at or beyond the configured memory size behave the same way. The topmost addresses get no special decode; they are ordinary storage. Read data comes from a synchronous memory. It appears on the output one clock after the read strobe and stays there until the next read strobe.

Top module: `nvram_idx_port`

## Requirements
- R1: A write at offset 0 replaces bits 7:0 of the pointer and a write at offset 1 replaces bits 15:8; the other half is kept.
- R2: A write at offset 3 stores the data byte at the pointer (when allowed) and the pointer is 0x0000 on the following cycle, whether or not the store was allowed.
- R3: A read strobe at offset 3 presents the byte at the pointer on the read-data output one cycle later and does not change the pointer.
- R4: A read strobe at offset 0, 1 or 2 presents 0xFF one cycle later; a write at offset 2 changes neither memory nor pointer.
- R5: Lock bit 0 guards addresses 0x0020–0x002F and lock bit 1 guards 0x0030–0x003F; while a guard is set, a store there is discarded and a read there returns 0xFF.
- R6: A cycle with the lock-toggle input high inverts the lock bit chosen by the lock-select input (0 or 1) and leaves the other bit unchanged.
- R7: With the pointer at or above MEM_BYTES, a store changes no memory byte (including the byte that shares its low address bits) and a read returns 0xFF.
- R8: Reset clears the pointer and both lock bits and makes the read-data output 0xFF; memory contents are kept across reset.
- R9: The read-data output holds its value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_off | input | 2 | Port offset: 0 pointer low, 1 pointer high, 2 spare, 3 data |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| lock_tgl | input | 1 | Request to invert one lock bit |
| lock_sel | input | 1 | Lock bit chosen by the toggle request |
| io_rdata | output | 8 | Read data, valid one cycle after the read strobe |

## Verification
The bench fills every location, then reads each one back. This exposes a pointer with a swapped or stale half, which would return bytes from the wrong address. It relies on the pointer clearing after a store, so a design that failed to clear would read the wrong byte at address 0. Each lock is exercised by locking, storing, unlocking and reading back. A lock that blocked reads but not writes, or that set instead of toggling, would show the new pattern or stay stuck at 0xFF. Out-of-range stores at an address that aliases a real location catch a design that drops the upper pointer bits. A reset issued while locks are set checks that the locks clear and the memory survives.

// File: rtl/nvp_pkg.sv
package nvp_pkg;

    typedef enum logic [1:0] {
        OFF_PTR_LO = 2'd0,
        OFF_PTR_HI = 2'd1,
        OFF_SPARE  = 2'd2,
        OFF_DATA   = 2'd3
    } io_off_e;

    localparam int PTR_W       = 16;
    localparam int BYTE_W      = 8;
    localparam int GUARD_COUNT = 2;
    localparam int GUARD_SEL_W = (GUARD_COUNT > 1) ? $clog2(GUARD_COUNT) : 1;
    localparam int GUARD_SPAN  = 16;
    localparam logic [PTR_W-1:0] GUARD_FIRST = 16'h0020;
    localparam logic [BYTE_W-1:0] BLANK_BYTE = 8'hFF;

    typedef struct packed {
        logic                  store;
        logic                  load;
        logic [PTR_W-1:0]      ptr;
        logic [BYTE_W-1:0]     data;
    } mem_req_t;

    function automatic logic [PTR_W-1:0] guard_base(input int idx);
        return GUARD_FIRST + PTR_W'(idx * GUARD_SPAN);
    endfunction

    function automatic logic in_guard(input logic [PTR_W-1:0] ptr, input int idx);
        logic [PTR_W-1:0] base;
        base = guard_base(idx);
        return (ptr >= base) && (ptr < base + PTR_W'(GUARD_SPAN));
    endfunction

endpackage

// File: rtl/nvp_ptr_reg.sv
module nvp_ptr_reg
    import nvp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  io_off_e           off,
    input  logic [BYTE_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (wr) begin
            unique case (off)
                OFF_PTR_LO: ptr_q[7:0]  <= wdata;
                OFF_PTR_HI: ptr_q[15:8] <= wdata;
                OFF_DATA:   ptr_q       <= '0;
                default:    ptr_q       <= ptr_q;
            endcase
        end
    end
endmodule

// File: rtl/nvp_guard.sv
module nvp_guard
    import nvp_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tgl,
    input  logic [GUARD_SEL_W-1:0] sel,
    input  logic [PTR_W-1:0]       ptr,
    output logic [GUARD_COUNT-1:0] lock_q,
    output logic                   blocked
);
    logic [GUARD_COUNT-1:0] hit;

    for (genvar g = 0; g < GUARD_COUNT; g++) begin : g_guard
        always_ff @(posedge clk) begin
            if (rst) begin
                lock_q[g] <= 1'b0;
            end else if (tgl && (sel == GUARD_SEL_W'(g))) begin
                lock_q[g] <= ~lock_q[g];
            end
        end
        assign hit[g] = lock_q[g] && in_guard(ptr, g);
    end

    assign blocked = |hit;
endmodule

// File: rtl/nvp_mem.sv
module nvp_mem
    import nvp_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[idx] <= wdata;
        if (re) rdata <= cells[idx];
    end
endmodule

// File: rtl/nvram_idx_port.sv
module nvram_idx_port
    import nvp_pkg::*;
#(
    parameter int MEM_BYTES = 1024,
    localparam int IDX_W = (MEM_BYTES > 1) ? $clog2(MEM_BYTES) : 1,
    localparam logic [PTR_W:0] LIMIT = (PTR_W+1)'(MEM_BYTES)
)(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  io_off,
    input  logic [7:0]  io_wdata,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic        lock_tgl,
    input  logic        lock_sel,
    output logic [7:0]  io_rdata
);
    io_off_e                off;
    logic [PTR_W-1:0]       ptr_q;
    logic [GUARD_COUNT-1:0] lock_q;
    logic                   blocked;
    logic                   in_range;
    logic                   allowed;
    mem_req_t               req;
    logic [BYTE_W-1:0]      mem_q;
    logic                   blank_q;

    assign off = io_off_e'(io_off);

    nvp_ptr_reg u_ptr (
        .clk   (clk),
        .rst   (rst),
        .wr    (io_wr),
        .off   (off),
        .wdata (io_wdata),
        .ptr_q (ptr_q)
    );

    nvp_guard u_guard (
        .clk     (clk),
        .rst     (rst),
        .tgl     (lock_tgl),
        .sel     (GUARD_SEL_W'(lock_sel)),
        .ptr     (ptr_q),
        .lock_q  (lock_q),
        .blocked (blocked)
    );

    assign in_range = ({1'b0, ptr_q} < LIMIT);
    assign allowed  = in_range && !blocked;

    always_comb begin
        req.store = io_wr && (off == OFF_DATA) && allowed;
        req.load  = io_rd && (off == OFF_DATA) && allowed;
        req.ptr   = ptr_q;
        req.data  = io_wdata;
    end

    nvp_mem #(.DEPTH(MEM_BYTES)) u_mem (
        .clk   (clk),
        .we    (req.store),
        .re    (req.load),
        .idx   (req.ptr[IDX_W-1:0]),
        .wdata (req.data),
        .rdata (mem_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            blank_q <= 1'b1;
        end else if (io_rd) begin
            blank_q <= !req.load;
        end
    end

    assign io_rdata = blank_q ? BLANK_BYTE : mem_q;
endmodule

// File: rtl/nvp_checker.sv
module nvp_checker #(
    parameter int MEM_BYTES = 1024
)(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  io_off,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic        lock_tgl,
    input  logic        lock_sel,
    input  logic [7:0]  io_rdata,
    input  logic [15:0] ptr_q,
    input  logic [1:0]  lock_q
);
    localparam logic [16:0] LIM = 17'(MEM_BYTES);

    a_r2_ptr_clears: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_off == 2'd3) |=> (ptr_q == 16'h0000));

    a_r3_read_keeps_ptr: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !io_wr) |=> $stable(ptr_q));

    a_r4_side_read_blank: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_off != 2'd3) |=> (io_rdata == 8'hFF));

    a_r5_locked_read_blank: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_off == 2'd3 &&
         ((lock_q[0] && ptr_q[15:4] == 12'h002) || (lock_q[1] && ptr_q[15:4] == 12'h003)))
        |=> (io_rdata == 8'hFF));

    a_r6_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        lock_tgl |=> (lock_q == ($past(lock_q) ^ (2'b01 << $past(lock_sel)))));

    a_r6_no_toggle_keeps: assert property (@(posedge clk) disable iff (rst)
        !lock_tgl |=> $stable(lock_q));

    a_r7_range_read_blank: assert property (@(posedge clk) disable iff (rst)
        (io_rd && io_off == 2'd3 && ({1'b0, ptr_q} >= LIM)) |=> (io_rdata == 8'hFF));

    a_r8_reset_state: assert property (@(posedge clk)
        rst |=> (ptr_q == 16'h0000 && lock_q == 2'b00 && io_rdata == 8'hFF));

    a_r9_hold_output: assert property (@(posedge clk) disable iff (rst)
        !io_rd |=> $stable(io_rdata));
endmodule

bind nvram_idx_port nvp_checker #(.MEM_BYTES(MEM_BYTES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_off   (io_off),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .lock_tgl (lock_tgl),
    .lock_sel (lock_sel),
    .io_rdata (io_rdata),
    .ptr_q    (ptr_q),
    .lock_q   (lock_q)
);

// File: tb/nvram_idx_port_tb.sv
module nvram_idx_port_tb;
    localparam int MEM = 1024;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] io_off = 2'd0;
    logic [7:0] io_wdata = 8'd0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic       lock_tgl = 1'b0;
    logic       lock_sel = 1'b0;
    logic [7:0] io_rdata;

    int total = 0;
    int bad = 0;
    logic [7:0] model [MEM];

    always #4 clk = ~clk;

    nvram_idx_port #(.MEM_BYTES(MEM)) u_dut (
        .clk(clk), .rst(rst), .io_off(io_off), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rd(io_rd), .lock_tgl(lock_tgl),
        .lock_sel(lock_sel), .io_rdata(io_rdata)
    );

    function automatic logic [7:0] pat(input int a, input int k);
        return 8'((a ^ (a >> 3) ^ (a >> 8) * 29 ^ k) & 255);
    endfunction

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic put(input logic [1:0] off, input logic [7:0] d);
        @(negedge clk);
        io_off = off; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic point(input int a);
        put(2'd0, 8'(a & 255));
        put(2'd1, 8'((a >> 8) & 255));
    endtask

    task automatic get(input logic [1:0] off, input logic [7:0] exp, input string tag);
        @(negedge clk);
        io_off = off; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        check(io_rdata, exp, tag);
    endtask

    task automatic toggle(input logic s);
        @(negedge clk);
        lock_tgl = 1'b1; lock_sel = s;
        @(negedge clk);
        lock_tgl = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(io_rdata, 8'hFF, "R8 reset output");

        // R1 R2: fill every byte; pointer clear makes each store need a fresh pointer
        for (int a = 0; a < MEM; a++) begin
            point(a);
            put(2'd3, pat(a, 0));
            model[a] = pat(a, 0);
        end
        // R3: read every byte back
        for (int a = 0; a < MEM; a++) begin
            point(a);
            get(2'd3, model[a], "R3 sweep read");
        end

        // R3: read again without reloading the pointer, R9 hold
        point(300);
        get(2'd3, model[300], "R3 first read");
        get(2'd3, model[300], "R3 pointer kept");
        repeat (5) @(negedge clk);
        check(io_rdata, model[300], "R9 output held");

        // R1: change only the low half
        point(16'h0123);
        put(2'd0, 8'h45);
        get(2'd3, model[16'h0145], "R1 low half replaced");
        put(2'd1, 8'h02);
        get(2'd3, model[16'h0245], "R1 high half replaced");

        // R2: after a store pointer is zero
        point(77);
        put(2'd3, 8'h5A); model[77] = 8'h5A;
        get(2'd3, model[0], "R2 pointer cleared");
        put(2'd0, 8'd77);
        get(2'd3, 8'h5A, "R2 stored byte");

        // R4: side offsets read blank, spare write ignored
        point(9);
        get(2'd0, 8'hFF, "R4 offset0 read");
        get(2'd1, 8'hFF, "R4 offset1 read");
        get(2'd2, 8'hFF, "R4 offset2 read");
        put(2'd2, 8'hC3);
        get(2'd3, model[9], "R4 spare write ignored");

        // R5 R6: lock window 0
        toggle(1'b0);
        for (int a = 16'h20; a < 16'h40; a++) begin
            point(a);
            put(2'd3, pat(a, 91));
            if (a >= 16'h30) model[a] = pat(a, 91);
        end
        for (int a = 16'h20; a < 16'h40; a++) begin
            point(a);
            get(2'd3, (a < 16'h30) ? 8'hFF : model[a], "R5 guard0 locked");
        end
        toggle(1'b0);
        for (int a = 16'h1F; a < 16'h31; a++) begin
            point(a);
            get(2'd3, model[a], "R6 guard0 toggled off, R5 store dropped");
        end

        // R5 R6: lock window 1, toggled twice
        toggle(1'b1);
        point(16'h35);
        put(2'd3, 8'h11);
        point(16'h35);
        get(2'd3, 8'hFF, "R5 guard1 locked read");
        point(16'h2F);
        get(2'd3, model[16'h2F], "R6 guard0 untouched by sel1");
        point(16'h40);
        get(2'd3, model[16'h40], "R5 just above guard1");
        toggle(1'b1);
        point(16'h35);
        get(2'd3, model[16'h35], "R5 guard1 store dropped");

        // R7: out of range
        point(MEM + 5);
        put(2'd3, ~model[5]);
        point(5);
        get(2'd3, model[5], "R7 alias not written");
        point(MEM + 5);
        get(2'd3, 8'hFF, "R7 range read");
        point(16'hFFFF);
        get(2'd3, 8'hFF, "R7 top read");
        point(MEM - 1);
        get(2'd3, model[MEM-1], "R7 last byte readable");

        // R8: reset while locked
        toggle(1'b0);
        toggle(1'b1);
        point(16'h0025);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(io_rdata, 8'hFF, "R8 output after reset");
        get(2'd3, model[0], "R8 pointer cleared");
        point(16'h25);
        get(2'd3, model[16'h25], "R8 guard0 cleared");
        point(16'h3A);
        get(2'd3, model[16'h3A], "R8 guard1 cleared");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule